// File: doc/BRIEF.md
# Multi-Field Cut-Tree Flow Lookup Engine

This block resolves a flow key (source and destination IPv4 address, source and destination transport port) to a rule identifier. It walks a decision tree that was already built and placed in a word-addressed memory. Each internal node cuts one header byte into 256 equal slices. Because the stride never changes, a lookup needs a known maximum number of memory reads. A leaf needs no rule scan, because cutting continued until each region was covered by a single rule set.

A node word holds four fields. The top two bits name the field to cut. The next two bits name the byte. Bits 27:20 hold an 8-bit group bitmap, and bits 19:0 hold the base of the child array, counted in 32-word blocks.

A set bitmap bit means its group of 32 cuts has one child entry per cut. A clear bit means the whole group shares one entry. The engine issues one read at a time over a valid/ready request channel and accepts a response after any latency. It reports either the leaf's rule identifier or an error when the walk does not end in time.

Top module: `pkt_cut_walker`

## Requirements
- R1: `key_ready` is high exactly while the engine is idle. A key is taken only on a cycle with `key_valid` and `key_ready` both high. Keys presented while a lookup is in progress have no effect on its reads or its result.
- R2: Node bits 31:30 choose the cut field: 0 source IP, 1 destination IP, 2 source port, 3 destination port.
- R3: Node bits 29:28 choose the byte of that field, viewed as 32 bits: 0 is bits 31:24, 1 is 23:16, 2 is 15:8 and 3 is 7:0. Port fields are zero-extended, so byte 0 and byte 1 of a port read as zero.
- R4: For cut index x, the group is g = x[7:5] and r is the count of set bitmap bits below g. When bitmap bit g is set, the child slot is r*32 + x[4:0].
- R5: When bitmap bit g is clear, the child slot is r*32, whatever the value of x[4:0].
- R6: The first read of a lookup goes to word address 0. Each later read goes to (base * 32 + slot), taken modulo 2^25.
- R7: A read word whose bits 31:30 are 11 and whose bits 27:20 are 0xFF is a leaf. The lookup ends with `res_rule` set to bits 19:0 of that word and `res_error` low.
- R8: A lookup makes at most 13 reads. If the 13th word read is not a leaf, the lookup ends with `res_error` high and `res_rule` zero, and no further read is issued.
- R9: Each accepted key yields exactly one result. `res_valid` is high for one cycle, on the cycle after the final response.
- R10: At most one read is outstanding. `mem_req_valid` stays high with a stable address until `mem_req_ready` is seen. Responses with any latency are accepted.
- R11: After reset, `key_ready` is high and `mem_req_valid` and `res_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| key_valid | input | 1 | Key offered |
| key_ready | output | 1 | Engine idle, key can be taken |
| key_sip | input | 32 | Source IPv4 address |
| key_dip | input | 32 | Destination IPv4 address |
| key_sport | input | 16 | Source transport port |
| key_dport | input | 16 | Destination transport port |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 25 | Word address to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| res_valid | output | 1 | Result strobe |
| res_rule | output | 20 | Matched rule identifier |
| res_error | output | 1 | Walk exceeded the read limit |

## Verification
The hardest situation to create from the ports is a walk that reaches the full depth. That needs a chain of 13 non-leaf nodes, each sitting at the exact address that the key and the previous node's bitmap produce. The bench builds that chain for every lookup. For each level it picks a random node, computes the child address from the key, and stores the next word there. It sets the depth to 13 reads with a leaf at the end, or to 13 non-leaf reads, so that both the boundary and the error path occur.

Random request back-pressure and response latency run throughout. Each lookup also checks every request address and the exact read count.

// File: rtl/pcw_pkg.sv
package pcw_pkg;

   localparam int NODE_W  = 32;
   localparam int BMAP_W  = 8;
   localparam int BSEL_W  = 2;
   localparam int DIM_W   = 2;

   typedef enum logic [1:0] {
      DIM_SRC_IP  = 2'b00,
      DIM_DST_IP  = 2'b01,
      DIM_SRC_PRT = 2'b10,
      DIM_DST_PRT = 2'b11
   } cut_dim_e;

   typedef struct packed {
      logic [DIM_W-1:0]  dim;
      logic [BSEL_W-1:0] bsel;
      logic [BMAP_W-1:0] bmap;
      logic [19:0]       base;
   } node_word_t;

   typedef enum logic [1:0] {
      WS_IDLE = 2'd0,
      WS_REQ  = 2'd1,
      WS_WAIT = 2'd2,
      WS_DONE = 2'd3
   } walk_state_e;

   function automatic logic node_is_leaf(input node_word_t n);
      return (n.dim == DIM_DST_PRT) && (n.bmap == {BMAP_W{1'b1}});
   endfunction

endpackage

// File: rtl/pcw_key_select.sv
module pcw_key_select #(
   parameter int IP_W   = 32,
   parameter int PORT_W = 16,
   parameter int STRIDE = 8
) (
   input  logic [IP_W-1:0]   sip,
   input  logic [IP_W-1:0]   dip,
   input  logic [PORT_W-1:0] sport,
   input  logic [PORT_W-1:0] dport,
   input  logic [1:0]        dim,
   input  logic [1:0]        bsel,
   output logic [STRIDE-1:0] cut_idx
);
   localparam int FIELD_W = IP_W;
   localparam int LANES   = FIELD_W / STRIDE;
   localparam int NFIELD  = 4;

   logic [FIELD_W-1:0] fld  [NFIELD];
   logic [STRIDE-1:0]  lane [NFIELD][LANES];

   assign fld[0] = sip;
   assign fld[1] = dip;
   assign fld[2] = FIELD_W'(sport);
   assign fld[3] = FIELD_W'(dport);

   generate
      for (genvar f = 0; f < NFIELD; f++) begin : g_fld
         for (genvar l = 0; l < LANES; l++) begin : g_lane
            assign lane[f][l] = fld[f][FIELD_W-1-l*STRIDE -: STRIDE];
         end
      end
   endgenerate

   assign cut_idx = lane[dim][bsel];

endmodule

// File: rtl/pcw_slot_rank.sv
module pcw_slot_rank #(
   parameter int GRP        = 8,
   parameter int SUB_LG     = 5,
   parameter int RANK_STYLE = 1
) (
   input  logic [GRP-1:0]                   bmap,
   input  logic [$clog2(GRP)+SUB_LG-1:0]    cut_idx,
   output logic [$clog2(GRP)+SUB_LG-1:0]    slot
);
   localparam int GRP_LG = $clog2(GRP);
   localparam int IDX_W  = GRP_LG + SUB_LG;
   localparam int RANK_W = GRP_LG + 1;

   logic [GRP_LG-1:0] grp;
   logic [SUB_LG-1:0] sub;
   logic [RANK_W-1:0] rank;
   logic              hit;

   assign grp = cut_idx[IDX_W-1:SUB_LG];
   assign sub = cut_idx[SUB_LG-1:0];
   assign hit = bmap[grp];

   generate
      if (RANK_STYLE == 1) begin : g_prefix
         logic [RANK_W-1:0] pre [GRP];
         assign pre[0] = '0;
         for (genvar i = 1; i < GRP; i++) begin : g_pre
            assign pre[i] = pre[i-1] + RANK_W'(bmap[i-1]);
         end
         assign rank = pre[grp];
      end else begin : g_masked
         always_comb begin
            rank = '0;
            for (int i = 0; i < GRP; i++) begin
               if (GRP_LG'(i) < grp) rank = rank + RANK_W'(bmap[i]);
            end
         end
      end
   endgenerate

   assign slot = {rank[GRP_LG-1:0], (hit ? sub : {SUB_LG{1'b0}})};

endmodule

// File: rtl/pcw_child_addr.sv
module pcw_child_addr #(
   parameter int BASE_W = 20,
   parameter int BLK_LG = 5,
   parameter int SLOT_W = 8
) (
   input  logic [BASE_W-1:0]        base,
   input  logic [SLOT_W-1:0]        slot,
   output logic [BASE_W+BLK_LG-1:0] addr
);
   localparam int ADDR_W = BASE_W + BLK_LG;

   assign addr = {base, {BLK_LG{1'b0}}} + ADDR_W'(slot);

endmodule

// File: rtl/pkt_cut_walker.sv
module pkt_cut_walker
   import pcw_pkg::*;
#(
   parameter int IP_W       = 32,
   parameter int PORT_W     = 16,
   parameter int STRIDE     = 8,
   parameter int BASE_W     = 20,
   parameter int RULE_W     = 20,
   parameter int MAX_READS  = 13,
   parameter int RANK_STYLE = 1,
   parameter int ROOT_ADDR  = 0,
   localparam int GRP       = BMAP_W,
   localparam int BLK_LG    = STRIDE - $clog2(GRP),
   localparam int ADDR_W    = BASE_W + BLK_LG,
   localparam int CNT_W     = $clog2(MAX_READS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_valid,
   output logic              key_ready,
   input  logic [IP_W-1:0]   key_sip,
   input  logic [IP_W-1:0]   key_dip,
   input  logic [PORT_W-1:0] key_sport,
   input  logic [PORT_W-1:0] key_dport,
   output logic              mem_req_valid,
   input  logic              mem_req_ready,
   output logic [ADDR_W-1:0] mem_req_addr,
   input  logic              mem_rsp_valid,
   input  logic [NODE_W-1:0] mem_rsp_data,
   output logic              res_valid,
   output logic [RULE_W-1:0] res_rule,
   output logic              res_error
);

   generate
      if (STRIDE != 8) begin : g_bad_stride
         $error("pkt_cut_walker: node format needs STRIDE of 8");
      end
      if (IP_W != 32 || PORT_W > IP_W) begin : g_bad_key
         $error("pkt_cut_walker: key field widths unsupported");
      end
      if (BASE_W != 20 || RULE_W > BASE_W) begin : g_bad_word
         $error("pkt_cut_walker: base or rule width unsupported");
      end
      if (MAX_READS < 1) begin : g_bad_depth
         $error("pkt_cut_walker: MAX_READS must be positive");
      end
   endgenerate

   walk_state_e        st_q;
   logic [IP_W-1:0]    sip_q, dip_q;
   logic [PORT_W-1:0]  sport_q, dport_q;
   logic [ADDR_W-1:0]  addr_q;
   logic [CNT_W-1:0]   reads_q;
   logic [RULE_W-1:0]  rule_q;
   logic               err_q;

   node_word_t         nd;
   logic [STRIDE-1:0]  cut_idx;
   logic [STRIDE-1:0]  slot;
   logic [ADDR_W-1:0]  child_addr;
   logic               leaf;

   assign nd   = node_word_t'(mem_rsp_data);
   assign leaf = node_is_leaf(nd);

   pcw_key_select #(
      .IP_W   (IP_W),
      .PORT_W (PORT_W),
      .STRIDE (STRIDE)
   ) key_sel_i (
      .sip     (sip_q),
      .dip     (dip_q),
      .sport   (sport_q),
      .dport   (dport_q),
      .dim     (nd.dim),
      .bsel    (nd.bsel),
      .cut_idx (cut_idx)
   );

   pcw_slot_rank #(
      .GRP        (GRP),
      .SUB_LG     (BLK_LG),
      .RANK_STYLE (RANK_STYLE)
   ) slot_i (
      .bmap    (nd.bmap),
      .cut_idx (cut_idx),
      .slot    (slot)
   );

   pcw_child_addr #(
      .BASE_W (BASE_W),
      .BLK_LG (BLK_LG),
      .SLOT_W (STRIDE)
   ) addr_i (
      .base (nd.base),
      .slot (slot),
      .addr (child_addr)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= WS_IDLE;
         sip_q   <= '0;
         dip_q   <= '0;
         sport_q <= '0;
         dport_q <= '0;
         addr_q  <= '0;
         reads_q <= '0;
         rule_q  <= '0;
         err_q   <= 1'b0;
      end else begin
         case (st_q)
            WS_IDLE: begin
               if (key_valid) begin
                  sip_q   <= key_sip;
                  dip_q   <= key_dip;
                  sport_q <= key_sport;
                  dport_q <= key_dport;
                  addr_q  <= ADDR_W'(ROOT_ADDR);
                  reads_q <= '0;
                  st_q    <= WS_REQ;
               end
            end
            WS_REQ: begin
               if (mem_req_ready) begin
                  reads_q <= reads_q + CNT_W'(1);
                  st_q    <= WS_WAIT;
               end
            end
            WS_WAIT: begin
               if (mem_rsp_valid) begin
                  if (leaf) begin
                     rule_q <= mem_rsp_data[RULE_W-1:0];
                     err_q  <= 1'b0;
                     st_q   <= WS_DONE;
                  end else if (reads_q == CNT_W'(MAX_READS)) begin
                     rule_q <= '0;
                     err_q  <= 1'b1;
                     st_q   <= WS_DONE;
                  end else begin
                     addr_q <= child_addr;
                     st_q   <= WS_REQ;
                  end
               end
            end
            default: st_q <= WS_IDLE;
         endcase
      end
   end

   assign key_ready     = (st_q == WS_IDLE);
   assign mem_req_valid = (st_q == WS_REQ);
   assign mem_req_addr  = addr_q;
   assign res_valid     = (st_q == WS_DONE);
   assign res_rule      = rule_q;
   assign res_error     = err_q;

endmodule

// File: rtl/pcw_walker_chk.sv
module pcw_walker_chk #(
   parameter int MAX_READS = 13,
   parameter int ADDR_W    = 25,
   parameter int RULE_W    = 20,
   parameter int ROOT_ADDR = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              key_valid,
   input logic              key_ready,
   input logic              mem_req_valid,
   input logic              mem_req_ready,
   input logic [ADDR_W-1:0] mem_req_addr,
   input logic              res_valid,
   input logic [RULE_W-1:0] res_rule,
   input logic              res_error
);
   localparam int SEEN_W = $clog2(MAX_READS + 2) + 1;

   logic [SEEN_W-1:0] seen_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen_q <= '0;
      else if (key_valid && key_ready) seen_q <= '0;
      else if (mem_req_valid && mem_req_ready) seen_q <= seen_q + SEEN_W'(1);
   end

   assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

   assert_res_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   assert_idle_after_res_R1: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> key_ready);

   assert_busy_after_key_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (key_valid && key_ready) |=> !key_ready);

   assert_no_req_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      key_ready |-> !mem_req_valid);

   assert_read_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      seen_q <= SEEN_W'(MAX_READS));

   assert_err_no_rule_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (res_valid && res_error) |-> (res_rule == '0));

   assert_root_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (key_valid && key_ready) |=> (mem_req_addr == ADDR_W'(ROOT_ADDR)));

endmodule

bind pkt_cut_walker pcw_walker_chk #(
   .MAX_READS (MAX_READS),
   .ADDR_W    (ADDR_W),
   .RULE_W    (RULE_W),
   .ROOT_ADDR (ROOT_ADDR)
) chk_i (
   .clk           (clk),
   .rst_n         (rst_n),
   .key_valid     (key_valid),
   .key_ready     (key_ready),
   .mem_req_valid (mem_req_valid),
   .mem_req_ready (mem_req_ready),
   .mem_req_addr  (mem_req_addr),
   .res_valid     (res_valid),
   .res_rule      (res_rule),
   .res_error     (res_error)
);

// File: tb/pkt_cut_walker_tb_top.sv
`timescale 1ns/1ps
module pkt_cut_walker_tb_top;

   localparam int MAXR = 13;
   localparam int AW   = 25;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        key_valid = 1'b0;
   logic        key_ready;
   logic [31:0] key_sip = '0, key_dip = '0;
   logic [15:0] key_sport = '0, key_dport = '0;
   logic        mem_req_valid;
   logic        mem_req_ready = 1'b0;
   logic [AW-1:0] mem_req_addr;
   logic        mem_rsp_valid = 1'b0;
   logic [31:0] mem_rsp_data = '0;
   logic        res_valid;
   logic [19:0] res_rule;
   logic        res_error;

   always #2 clk = ~clk;

   pkt_cut_walker dut_i (
      .clk(clk), .rst_n(rst_n),
      .key_valid(key_valid), .key_ready(key_ready),
      .key_sip(key_sip), .key_dip(key_dip),
      .key_sport(key_sport), .key_dport(key_dport),
      .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
      .mem_req_addr(mem_req_addr),
      .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
      .res_valid(res_valid), .res_rule(res_rule), .res_error(res_error)
   );

   int n_checks = 0;
   int n_err    = 0;
   int got_reads = 0;
   int exp_reads = 0;
   string cur_tag = "";
   logic [31:0]   tree_q [logic [AW-1:0]];
   logic [AW-1:0] exp_addr [0:15];

   task automatic check(input bit ok, input string tag, input string what,
                        input longint act, input longint expv);
      n_checks++;
      if (!ok) begin
         n_err++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
      end
   endtask

   function automatic logic [7:0] f_index(input logic [31:0] s, input logic [31:0] d,
                                          input logic [15:0] sp, input logic [15:0] dp,
                                          input logic [1:0] dim, input logic [1:0] bsel);
      logic [31:0] f;
      case (dim)
         2'd0: f = s;
         2'd1: f = d;
         2'd2: f = {16'h0, sp};
         default: f = {16'h0, dp};
      endcase
      return f[31 - 8*int'(bsel) -: 8];
   endfunction

   function automatic logic [7:0] f_slot(input logic [7:0] bmp, input logic [7:0] x);
      int g = int'(x[7:5]);
      logic [2:0] r = '0;
      for (int i = 0; i < g; i++) r = r + 3'(bmp[i]);
      return bmp[g] ? {r, x[4:0]} : {r, 5'd0};
   endfunction

   function automatic logic [AW-1:0] f_child(input logic [31:0] w, input logic [7:0] x);
      return {w[19:0], 5'd0} + AW'(f_slot(w[27:20], x));
   endfunction

   // handshake capture and memory responder
   logic          hs_q = 1'b0;
   logic [AW-1:0] hs_addr_q = '0;
   always @(posedge clk) begin
      hs_q      <= mem_req_valid && mem_req_ready;
      hs_addr_q <= mem_req_addr;
   end

   initial begin
      int delay = -1;
      logic [AW-1:0] pend = '0;
      forever begin
         @(negedge clk);
         mem_rsp_valid = 1'b0;
         if (hs_q) begin
            if (got_reads < exp_reads)
               check(hs_addr_q == exp_addr[got_reads], cur_tag, "read address",
                     longint'(hs_addr_q), longint'(exp_addr[got_reads]));
            else
               check(1'b0, "R8", "read beyond expected count", got_reads + 1, exp_reads);
            got_reads++;
            pend  = hs_addr_q;
            delay = $urandom_range(0, 3);
         end
         if (delay == 0) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_data  = tree_q.exists(pend) ? tree_q[pend] : 32'h0;
            delay = -1;
         end else if (delay > 0) begin
            delay--;
         end
         mem_req_ready = ($urandom_range(0, 2) != 0);
      end
   end

   task automatic run_lookup(input string tag, input int nodes, input bit leaf,
                             input bit fix, input logic [1:0] fdim, input logic [1:0] fbsel,
                             input logic [7:0] fbmp, input bit spam, input logic [19:0] rule);
      logic [31:0] s = $urandom, d = $urandom;
      logic [15:0] sp = 16'($urandom), dp = 16'($urandom);
      logic [AW-1:0] a = '0;
      int cnt = 0;
      tree_q.delete();
      for (int lvl = 0; lvl < nodes; lvl++) begin
         logic [1:0] dm = fix ? fdim  : 2'($urandom);
         logic [1:0] bs = fix ? fbsel : 2'($urandom);
         logic [7:0] bm = fix ? fbmp  : 8'($urandom);
         logic [19:0] bs20 = {5'(lvl + 1), 15'($urandom)};
         logic [31:0] w;
         if (dm == 2'd3 && bm == 8'hFF) bm = 8'hFE;
         w = {dm, bs, bm, bs20};
         tree_q[a] = w;
         exp_addr[lvl] = a;
         a = f_child(w, f_index(s, d, sp, dp, dm, bs));
      end
      if (leaf) begin
         tree_q[a] = {2'b11, 2'($urandom), 8'hFF, rule};
         exp_addr[nodes] = a;
         exp_reads = nodes + 1;
      end else begin
         exp_reads = nodes;
      end
      got_reads = 0;
      cur_tag = tag;
      @(negedge clk);
      key_sip = s; key_dip = d; key_sport = sp; key_dport = dp;
      key_valid = 1'b1;
      @(negedge clk);
      check(key_ready == 1'b0, "R1", "key_ready while busy", key_ready, 0);
      key_valid = spam;
      while (!res_valid && cnt < 3000) begin
         if (spam) begin
            key_sip = $urandom; key_dip = $urandom;
            key_sport = 16'($urandom); key_dport = 16'($urandom);
         end
         @(negedge clk);
         cnt++;
      end
      key_valid = 1'b0;
      if (!res_valid) begin
         check(1'b0, tag, "no result (timeout)", 0, 1);
         return;
      end
      check(res_error == !leaf, leaf ? "R7" : "R8", "res_error", res_error, !leaf);
      check(res_rule == (leaf ? rule : 20'h0), leaf ? "R7" : "R8", "res_rule",
            res_rule, leaf ? rule : 20'h0);
      check(got_reads == exp_reads, "R8 R10", "read count", got_reads, exp_reads);
      @(negedge clk);
      check(res_valid == 1'b0, "R9", "res_valid one cycle", res_valid, 0);
      check(key_ready == 1'b1, "R1", "idle after result", key_ready, 1);
   endtask

   initial begin
      int cyc = 0;
      forever begin
         @(posedge clk);
         cyc++;
         if (cyc > 150000) begin
            check(1'b0, "R9", "watchdog expired", cyc, 150000);
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
         end
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check(key_ready == 1'b1, "R11", "key_ready in reset", key_ready, 1);
      check(mem_req_valid == 1'b0, "R11", "mem_req_valid in reset", mem_req_valid, 0);
      check(res_valid == 1'b0, "R11", "res_valid in reset", res_valid, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(key_ready == 1'b1, "R11", "key_ready after reset", key_ready, 1);

      // root is a leaf: single read of address 0
      run_lookup("R6 R7", 0, 1'b1, 1'b0, 2'd0, 2'd0, 8'h00, 1'b0, 20'hABCDE);
      // every field and byte selector
      for (int dm = 0; dm < 4; dm++)
         for (int bs = 0; bs < 4; bs++)
            run_lookup("R2 R3", 1, 1'b1, 1'b1, 2'(dm), 2'(bs), 8'($urandom),
                       1'b0, 20'($urandom));
      // all groups clear, all groups set, alternating
      run_lookup("R5", 3, 1'b1, 1'b1, 2'd1, 2'd2, 8'h00, 1'b0, 20'h00011);
      run_lookup("R4", 3, 1'b1, 1'b1, 2'd0, 2'd3, 8'hFF, 1'b0, 20'h00022);
      run_lookup("R4 R5", 4, 1'b1, 1'b1, 2'd2, 2'd3, 8'hA5, 1'b0, 20'h00033);
      // depth boundary: exactly 13 reads ending in a leaf, then 13 non-leaves
      run_lookup("R8", MAXR - 1, 1'b1, 1'b0, 2'd0, 2'd0, 8'h00, 1'b0, 20'hFFFFF);
      run_lookup("R8", MAXR, 1'b0, 1'b0, 2'd0, 2'd0, 8'h00, 1'b0, 20'h0);
      // keys offered while busy are ignored
      run_lookup("R1", 6, 1'b1, 1'b0, 2'd0, 2'd0, 8'h00, 1'b1, 20'h5A5A5);
      run_lookup("R1", MAXR, 1'b0, 1'b0, 2'd0, 2'd0, 8'h00, 1'b1, 20'h0);
      // random walks with random back-pressure and latency
      for (int n = 0; n < 150; n++) begin
         int depth = $urandom_range(0, MAXR);
         bit lf = (depth < MAXR);
         run_lookup("R4 R5 R6 R10", depth, lf, 1'b0, 2'd0, 2'd0, 8'h00,
                    ($urandom_range(0, 3) == 0), 20'($urandom));
      end
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
   end

endmodule